// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a 32-bit linear address. A logical address is a 16-bit segment selector plus a 32-bit offset. The block has three segment slots: code, stack and data. Each slot holds a selector and a cached copy of the decoded descriptor for that selector. Loading a selector into a slot starts a descriptor fetch. The descriptor address is built from the global or local table base. The block then reads the 8-byte descriptor as two 32-bit words over a valid/ready read port. It checks the present flag and the privilege rules, and commits the descriptor to the slot only if both checks pass.

After a slot is loaded, translation requests name a slot and an offset. The block answers them one cycle later from the cached descriptor alone. The answer is the base plus the offset, together with a fault flag for an offset beyond the limit or an unloaded slot. While a fetch is in progress, requests to the slot being loaded are held off. Requests to the other slots go through.

Top module: `seg_xlate_unit`

## Requirements
- R1: A selector carries the descriptor index in bits 15:3, the table select in bit 2 and the requested privilege in bits 1:0. The descriptor address is the table base plus index*8: the global base when bit 2 is 0, the local base when bit 2 is 1.
- R2: A load reads two words. The first is descriptor bits 31:0 at the descriptor address. The second is bits 63:32 at that address plus 4. A word transfers in a cycle where rd_valid and rd_ready are both high. While rd_ready is low, rd_valid and rd_addr hold steady.
- R3: busy is high from the cycle after a load is accepted until ld_done pulses, and busy is low in the ld_done cycle. ld_done pulses for one cycle, the cycle after the second word transfers, with ld_fault valid alongside it. A load request made while busy is high is ignored.
- R4: Translations never start a memory read. rd_valid is high only while a load fetch is in progress.
- R5: xl_lin is descriptor base plus offset, modulo 2^32. The result, xl_out_valid and xl_fault appear on the cycle after the request is accepted.
- R6: The limit is {bits 51:48, bits 15:0}. With bit 55 (granularity) at 0 the effective limit is the limit itself. With bit 55 at 1 it is (limit<<12)|0xFFF. An offset greater than the effective limit sets xl_fault.
- R7: A descriptor with bit 47 (present) at 0 makes the load end with ld_fault. The slot then keeps its previous selector and descriptor.
- R8: Slot codes are 0 code, 1 stack, 2 data. The current privilege is bits 1:0 of the last committed code selector, and it is 0 after reset. A stack or data load faults when the larger of the current privilege and the selector's requested privilege exceeds the descriptor privilege in bits 46:45. Code loads skip this check.
- R9: While busy, xl_ready is low for the slot being loaded and high for every other slot.
- R10: After reset, busy and xl_out_valid are low and every slot is unloaded. A translation through an unloaded slot returns xl_fault.
- R11: The base is {bits 63:56, bits 39:32, bits 31:16} of the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| ld_valid | input | 1 | Load a selector into a slot |
| ld_seg | input | 2 | Slot to load (0 code, 1 stack, 2 data) |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse at the end of a load |
| ld_fault | output | 1 | Load outcome, valid with ld_done |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read word address |
| rd_ready | input | 1 | Memory accepts the read; rd_data is valid |
| rd_data | input | 32 | Memory read data |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 2 | Slot used for the translation |
| xl_off | input | 32 | Offset |
| xl_ready | output | 1 | Translation request can be accepted |
| xl_out_valid | output | 1 | Translation result valid |
| xl_lin | output | 32 | Linear address |
| xl_fault | output | 1 | Limit violation or unloaded slot |

## Verification
The bench runs loads through both table bases with different indices, which separates index scaling from table selection. It runs one fetch with wait states on the read port, to show that the handshake holds the address while rd_ready is low. Translations probe offsets exactly at and one past the effective limit under both granularities, and the unloaded state after reset. One base-plus-offset case crosses 2^32, to show the wrap. Privilege cases vary the current privilege and the requested privilege one at a time, so that each input to the max comparison is checked on its own. A not-present descriptor shows that a faulting load leaves the slot untouched. A fetch held mid-way shows that the stall applies per slot and that a second load request is dropped.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int SEG_N  = 3;
  localparam int SEG_W  = 2;

  localparam logic [SEG_W-1:0] SEG_CODE  = 2'd0;
  localparam logic [SEG_W-1:0] SEG_STACK = 2'd1;
  localparam logic [SEG_W-1:0] SEG_DATA  = 2'd2;

  typedef struct packed {
    logic              valid;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;
    logic [1:0]        dpl;
  } seg_entry_t;
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [1:0]        cpl,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic              busy,
  output logic [SEG_W-1:0]  busy_seg,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              fault,
  output logic              commit_en,
  output logic [SEG_W-1:0]  commit_seg,
  output seg_entry_t        commit_entry
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_e;
  fstate_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEG_W-1:0]  seg_q;
  logic [SEL_W-1:0]  sel_q;
  logic [31:0]       lo_q;

  logic [63:0] desc;
  logic [19:0] lim20;
  logic [1:0]  rpl, eff_priv, dpl;
  logic        present, gran, priv_bad, fault_c;
  seg_entry_t  dec;

  always_comb begin
    desc     = {rd_data, lo_q};
    lim20    = {desc[51:48], desc[15:0]};
    present  = desc[47];
    dpl      = desc[46:45];
    gran     = desc[55];
    rpl      = sel_q[1:0];
    eff_priv = (cpl > rpl) ? cpl : rpl;
    priv_bad = (seg_q != SEG_CODE) && (eff_priv > dpl);
    fault_c  = !present || priv_bad;
    dec.valid = 1'b1;
    dec.sel   = sel_q;
    dec.base  = {desc[63:56], desc[39:32], desc[31:16]};
    dec.lim   = gran ? {lim20, 12'hFFF} : {12'h000, lim20};
    dec.dpl   = dpl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= F_IDLE;
      addr_q       <= '0;
      seg_q        <= '0;
      sel_q        <= '0;
      lo_q         <= '0;
      done         <= 1'b0;
      fault        <= 1'b0;
      commit_en    <= 1'b0;
      commit_seg   <= '0;
      commit_entry <= '0;
    end else begin
      done      <= 1'b0;
      commit_en <= 1'b0;
      case (state_q)
        F_IDLE: if (ld_valid) begin
          addr_q  <= (ld_sel[2] ? ldt_base : gdt_base) + {{(ADDR_W-16){1'b0}}, ld_sel[15:3], 3'b000};
          seg_q   <= ld_seg;
          sel_q   <= ld_sel;
          state_q <= F_LO;
        end
        F_LO: if (rd_ready) begin
          lo_q    <= rd_data;
          addr_q  <= addr_q + 4;
          state_q <= F_HI;
        end
        F_HI: if (rd_ready) begin
          state_q      <= F_IDLE;
          done         <= 1'b1;
          fault        <= fault_c;
          commit_en    <= !fault_c;
          commit_seg   <= seg_q;
          commit_entry <= dec;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != F_IDLE);
  assign busy_seg = seg_q;
  assign rd_valid = (state_q != F_IDLE);
  assign rd_addr  = addr_q;

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)) else $error("hold"); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R3
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_en,
  input  logic [SEG_W-1:0] commit_seg,
  input  seg_entry_t       commit_entry,
  input  logic [SEG_W-1:0] rd_seg,
  output seg_entry_t       rd_entry,
  output logic [1:0]       cpl
);
  seg_entry_t ents [SEG_N];

  for (genvar i = 0; i < SEG_N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) ents[i] <= '0;
      else if (commit_en && commit_seg == SEG_W'(i)) ents[i] <= commit_entry;
    end
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < SEG_N; i++)
      if (rd_seg == SEG_W'(i)) rd_entry = ents[i];
  end

  assign cpl = ents[0].sel[1:0];

  AST_CPL_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    commit_en && commit_seg == SEG_CODE |=> cpl == $past(commit_entry.sel[1:0])) else $error("cpl"); // R8
  AST_KEEP_ON_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(ents[SEG_N-1])) else $error("slot changed"); // R7
endmodule

// File: rtl/seg_xlate_path.sv
module seg_xlate_path
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] off,
  input  seg_entry_t        entry,
  output logic              out_valid,
  output logic [ADDR_W-1:0] lin,
  output logic              fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      lin       <= '0;
      fault     <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        lin   <= entry.base + off;
        fault <= !entry.valid || (off > entry.lim);
      end
    end
  end

  AST_UNLOADED_FAULT: assert property (@(posedge clk) disable iff (rst)
    accept && !entry.valid |=> out_valid && fault) else $error("unloaded"); // R10
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] gdt_base,
  input  logic [31:0] ldt_base,
  input  logic        ld_valid,
  input  logic [1:0]  ld_seg,
  input  logic [15:0] ld_sel,
  output logic        busy,
  output logic        ld_done,
  output logic        ld_fault,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  input  logic        xl_valid,
  input  logic [1:0]  xl_seg,
  input  logic [31:0] xl_off,
  output logic        xl_ready,
  output logic        xl_out_valid,
  output logic [31:0] xl_lin,
  output logic        xl_fault
);
  logic [SEG_W-1:0] busy_seg, commit_seg;
  logic             commit_en;
  seg_entry_t       commit_entry, xl_entry;
  logic [1:0]       cpl;

  seg_desc_fetch u_fetch (
    .clk, .rst, .ld_valid, .ld_seg, .ld_sel, .gdt_base, .ldt_base, .cpl,
    .rd_ready, .rd_data, .busy, .busy_seg, .rd_valid, .rd_addr,
    .done(ld_done), .fault(ld_fault), .commit_en, .commit_seg, .commit_entry
  );

  seg_cache_bank u_bank (
    .clk, .rst, .commit_en, .commit_seg, .commit_entry,
    .rd_seg(xl_seg), .rd_entry(xl_entry), .cpl
  );

  assign xl_ready = !(busy && (xl_seg == busy_seg));

  seg_xlate_path u_path (
    .clk, .rst, .accept(xl_valid && xl_ready), .off(xl_off), .entry(xl_entry),
    .out_valid(xl_out_valid), .lin(xl_lin), .fault(xl_fault)
  );

  AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_valid) else $error("read outside fetch"); // R4
  AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    ld_done && ld_fault |-> !commit_en) else $error("commit on fault"); // R7
endmodule

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] gdt_base = 32'h0002_0000, ldt_base = 32'h0040_0000;
  logic ld_valid = 0; logic [1:0] ld_seg = 0; logic [15:0] ld_sel = 0;
  logic busy, ld_done, ld_fault, rd_valid, rd_ready, xl_ready, xl_out_valid, xl_fault;
  logic [31:0] rd_addr, rd_data, xl_lin;
  logic xl_valid = 0; logic [1:0] xl_seg = 0; logic [31:0] xl_off = 0;

  logic [63:0] cur_desc = '0;
  logic slow = 0, hold = 0;
  logic [1:0] cyc = 0;
  int errors = 0, checks = 0, log_n = 0;
  logic [31:0] addr_log [4];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rd_ready = rd_valid && !hold && (!slow || cyc == 2'd3);
  assign rd_data  = rd_addr[2] ? cur_desc[63:32] : cur_desc[31:0];

  always @(negedge clk)
    if (rd_valid && rd_ready) begin
      if (log_n < 4) addr_log[log_n] = rd_addr;
      log_n = log_n + 1;
    end

  seg_xlate_unit u_dut (.*);

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input logic g, input logic p, input logic [1:0] dpl);
    logic [63:0] d = '0;
    d[15:0] = lim[15:0]; d[31:16] = base[15:0]; d[39:32] = base[23:16];
    d[43:40] = 4'h2; d[44] = 1'b1; d[46:45] = dpl; d[47] = p;
    d[51:48] = lim[19:16]; d[54] = 1'b1; d[55] = g; d[63:56] = base[31:24];
    return d;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] seg, input logic [15:0] sel, input logic [63:0] d,
                         output logic flt);
    cur_desc = d;
    @(negedge clk); log_n = 0; ld_valid = 1; ld_seg = seg; ld_sel = sel;
    @(negedge clk); ld_valid = 0;
    for (int i = 0; i < 60; i++) begin
      if (ld_done) break;
      @(negedge clk);
    end
    flt = ld_fault;
  endtask

  task automatic xlate(input logic [1:0] seg, input logic [31:0] off, input string req,
                       input logic [31:0] exp_lin, input logic exp_flt);
    @(negedge clk); xl_valid = 1; xl_seg = seg; xl_off = off;
    @(negedge clk); xl_valid = 0;
    chk(xl_out_valid == 1'b1, req, {31'd0, xl_out_valid}, 32'd1);
    chk(xl_fault == exp_flt, req, {31'd0, xl_fault}, {31'd0, exp_flt});
    if (!exp_flt) chk(xl_lin == exp_lin, req, xl_lin, exp_lin);
  endtask

  task automatic t_reset;
    chk(busy == 0 && rd_valid == 0 && xl_out_valid == 0, "R10 reset outputs",
        {busy, rd_valid, xl_out_valid}, 32'd0);
    xlate(2'd2, 32'h0, "R10 unloaded slot faults", 32'h0, 1'b1);
  endtask

  task automatic t_gdt;
    logic f;
    do_load(2'd0, 16'h0010, mk(32'h0000_1000, 20'h0FFFF, 0, 1, 2'd0), f);
    chk(f == 0, "R1 code load ok", {31'd0, f}, 32'd0);
    chk(log_n == 2, "R2 two words", log_n, 2);
    chk(addr_log[0] == 32'h0002_0010, "R1 global index*8", addr_log[0], 32'h0002_0010);
    chk(addr_log[1] == 32'h0002_0014, "R2 second word +4", addr_log[1], 32'h0002_0014);
    log_n = 0;
    xlate(2'd0, 32'h10, "R5 R11 base plus offset", 32'h0000_1010, 1'b0);
    xlate(2'd0, 32'hFFFF, "R6 byte limit edge", 32'h0001_0FFF, 1'b0);
    xlate(2'd0, 32'h1_0000, "R6 byte limit +1", 32'h0, 1'b1);
    chk(log_n == 0, "R4 no reads on translate", log_n, 0);
  endtask

  task automatic t_ldt;
    logic f;
    slow = 1;
    do_load(2'd1, 16'h002C, mk(32'h8000_0000, 20'h00001, 1, 1, 2'd0), f);
    slow = 0;
    chk(f == 0, "R8 stack load cpl0", {31'd0, f}, 32'd0);
    chk(addr_log[0] == 32'h0040_0028, "R1 local table", addr_log[0], 32'h0040_0028);
    chk(addr_log[1] == 32'h0040_002C, "R2 wait states", addr_log[1], 32'h0040_002C);
    xlate(2'd1, 32'h1FFF, "R6 page limit edge", 32'h8000_1FFF, 1'b0);
    xlate(2'd1, 32'h2000, "R6 page limit +1", 32'h0, 1'b1);
  endtask

  task automatic t_wrap;
    logic f;
    do_load(2'd2, 16'h0018, mk(32'hFFFF_F000, 20'hFFFFF, 1, 1, 2'd0), f);
    chk(f == 0, "R5 data load", {31'd0, f}, 32'd0);
    xlate(2'd2, 32'h2000, "R5 wrap mod 2^32", 32'h0000_1000, 1'b0);
    xlate(2'd2, 32'hFFFF_FFFF, "R6 full 4G limit", 32'hFFFF_EFFF, 1'b0);
  endtask

  task automatic t_absent;
    logic f;
    do_load(2'd2, 16'h0018, mk(32'h0000_5000, 20'hFFFFF, 1, 0, 2'd0), f);
    chk(f == 1, "R7 not present faults", {31'd0, f}, 32'd1);
    xlate(2'd2, 32'h2000, "R7 slot kept", 32'h0000_1000, 1'b0);
  endtask

  task automatic t_priv;
    logic f;
    do_load(2'd0, 16'h0013, mk(32'h0000_1000, 20'h0FFFF, 0, 1, 2'd0), f);
    chk(f == 0, "R8 code load no priv check", {31'd0, f}, 32'd0);
    do_load(2'd2, 16'h0018, mk(32'h0000_7000, 20'hFFFFF, 1, 1, 2'd0), f);
    chk(f == 1, "R8 cpl3 vs dpl0", {31'd0, f}, 32'd1);
    xlate(2'd2, 32'h2000, "R8 slot kept on priv fault", 32'h0000_1000, 1'b0);
    do_load(2'd2, 16'h0018, mk(32'h0000_7000, 20'hFFFFF, 1, 1, 2'd3), f);
    chk(f == 0, "R8 cpl3 vs dpl3", {31'd0, f}, 32'd0);
    xlate(2'd2, 32'h0, "R8 dpl3 committed", 32'h0000_7000, 1'b0);
    do_load(2'd0, 16'h0010, mk(32'h0000_1000, 20'h0FFFF, 0, 1, 2'd0), f);
    do_load(2'd2, 16'h001B, mk(32'h0000_9000, 20'hFFFFF, 1, 1, 2'd0), f);
    chk(f == 1, "R8 rpl3 vs dpl0", {31'd0, f}, 32'd1);
    do_load(2'd2, 16'h0018, mk(32'h0000_9000, 20'hFFFFF, 1, 1, 2'd0), f);
    chk(f == 0, "R8 rpl0 cpl0 dpl0", {31'd0, f}, 32'd0);
  endtask

  task automatic t_stall;
    logic f;
    @(posedge clk); #2 hold = 1;
    cur_desc = mk(32'h0000_A000, 20'hFFFFF, 1, 1, 2'd0);
    @(negedge clk); log_n = 0; ld_valid = 1; ld_seg = 2'd2; ld_sel = 16'h0018;
    @(negedge clk); ld_valid = 0;
    chk(busy == 1, "R3 busy after accept", {31'd0, busy}, 32'd1);
    xl_seg = 2'd2; #1;
    chk(xl_ready == 0, "R9 loading slot stalled", {31'd0, xl_ready}, 32'd0);
    xl_seg = 2'd1; #1;
    chk(xl_ready == 1, "R9 other slot free", {31'd0, xl_ready}, 32'd1);
    xlate(2'd1, 32'h10, "R9 translate during fetch", 32'h8000_0010, 1'b0);
    @(negedge clk); ld_valid = 1; ld_seg = 2'd0; ld_sel = 16'h0020;
    @(negedge clk); ld_valid = 0;
    chk(rd_addr == 32'h0002_0018, "R2 address held", rd_addr, 32'h0002_0018);
    @(posedge clk); #2 hold = 0;
    for (int i = 0; i < 20; i++) begin
      if (ld_done) break;
      @(negedge clk);
    end
    f = ld_fault;
    chk(ld_done == 1 && busy == 0, "R3 done with busy low", {busy, ld_done}, 32'd1);
    chk(f == 0, "R3 stalled load ok", {31'd0, f}, 32'd0);
    repeat (3) @(negedge clk);
    chk(busy == 0 && log_n == 2, "R3 load during busy ignored", log_n, 2);
    xlate(2'd0, 32'h10, "R3 code slot unchanged", 32'h0000_1010, 1'b0);
    xlate(2'd2, 32'h4, "R5 new data base", 32'h0000_A004, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset; t_gdt; t_ldt; t_wrap; t_absent; t_priv; t_stall;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule